// File: doc/BRIEF.md
# Four-Channel Peripheral Byte DMA Engine

This block moves bytes between a 16-bit-addressed memory and a small set of fixed peripheral byte ports, with no processor involvement once a channel is armed. Each of its four channels holds a base address, a byte count, a running offset, an endpoint code and a replay bit. Each cycle, the lowest-numbered channel that is armed and whose endpoint and memory are both ready moves one byte. That byte travels from memory at base plus offset to one of three peripheral input ports, or from the single peripheral output port into memory.

Software reaches the per-channel registers through a bank pointer, so one set of register addresses serves every channel. A shared arm register and a shared done-flag register each hold one bit per channel. A channel in replay mode goes back to the start of its buffer whenever the buffer runs out. This lets a short buffer, such as a key, be supplied again and again while the other channels stream linear data. A linear channel flags completion, disarms itself, and can raise the interrupt line.

Top module: `pdma_engine`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_req` is low.
- R2: Register addresses are 0 arm, 1 done flags, 2 bank pointer, 3 endpoint config, 4 mode, 5/6 base high/low, 7/8 count high/low, 9/10 offset high/low. The pointer keeps its low two bits. Addresses 3 to 10 read and write only the channel that the pointer names.
- R3: Base, count and offset are 16-bit values, each written and read back as two bytes. The offset read back after a run equals the number of bytes moved, modulo the count when replay is on.
- R4: An armed channel with config bits [3:0] equal to 5, 6 or 7 reads memory at base+offset and presents the byte on `pin_data`, with `pin_strobe` bit 0, 1 or 2 set. Its offset then advances by one. This happens only in a cycle when that port's `pin_ready` bit is high.
- R5: Config code 8 takes `pout_data` while `pout_valid` is high, pulses `pout_take`, and writes the byte to memory at base+offset with `mem_we` high.
- R6: Any other config code never moves a byte, and the channel stays armed.
- R7: A channel with mode bit 0 clear moves exactly count bytes. On the last byte it sets its done flag and clears its arm bit.
- R8: A channel with mode bit 0 set wraps its offset to zero when the offset reaches the count. It keeps moving bytes, and it never sets its flag or clears its arm bit.
- R9: `irq` is high exactly while some channel has its done flag set and config bit 7 set.
- R10: Writing the flag register clears each flag whose written bit is 0 and leaves flags whose written bit is 1.
- R11: Writing 0 to the arm register stops all movement from the next cycle.
- R12: At most one byte moves per clock, and only while `mem_ready` is high. Among channels that can move, the lowest number wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | A byte moves this cycle |
| mem_we | output | 1 | The moving byte is written to memory |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| mem_ready | input | 1 | Memory can serve a byte this cycle |
| pin_ready | input | 3 | Each peripheral input port can accept a byte |
| pin_strobe | output | 3 | Byte delivered to the given peripheral input port |
| pin_data | output | 8 | Byte delivered to the peripheral input ports |
| pout_valid | input | 1 | Peripheral output port holds a byte |
| pout_data | input | 8 | Byte from the peripheral output port |
| pout_take | output | 1 | Byte taken from the peripheral output port |
| irq | output | 1 | Completion interrupt |

## Verification
The bench aims at the last byte of a linear run. An off-by-one in the count compare there would move one byte too many or too few, and would leave the channel armed. It drives base and offset sums that carry from the low byte into the high byte, and a replay buffer that crosses a 4 KB boundary. These catch a design that adds only the low byte or wraps to the wrong value. It sweeps several phases of port and memory readiness, so a design that moves a byte while either side is stalled shows up as extra or misplaced addresses. It also runs two competing channels and an unknown endpoint code, which expose wrong priority and bytes moved to nowhere.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

   localparam int unsigned REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      RA_ARM    = 4'd0,
      RA_FLAG   = 4'd1,
      RA_BANK   = 4'd2,
      RA_CFG    = 4'd3,
      RA_MODE   = 4'd4,
      RA_BASE_H = 4'd5,
      RA_BASE_L = 4'd6,
      RA_CNT_H  = 4'd7,
      RA_CNT_L  = 4'd8,
      RA_OFS_H  = 4'd9,
      RA_OFS_L  = 4'd10
   } reg_addr_e;

   // endpoint code of the first peripheral input port; the next codes follow in order
   localparam int unsigned EP_FIRST_IN = 5;
   // bit of the config register that enables the completion interrupt
   localparam int unsigned CFG_IE_BIT  = 7;
   localparam int unsigned CODE_W      = 4;

   function automatic logic [7:0] hi_byte(input logic [15:0] v);
      return v[15:8];
   endfunction

   function automatic logic [7:0] lo_byte(input logic [15:0] v);
      return v[7:0];
   endfunction

endpackage

// File: rtl/pdma_chan.sv
module pdma_chan
   import pdma_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   input  logic              step,
   output logic [DW-1:0]     bank_rdata,
   output logic [CODE_W-1:0] code,
   output logic              irq_en,
   output logic [AW-1:0]     addr,
   output logic              done
);

   localparam int unsigned HW = AW - 8;

   generate
      if (AW < 9 || AW > 16) begin : g_bad_aw
         $error("pdma_chan: AW must lie in 9..16");
      end
      if (DW != 8) begin : g_bad_dw
         $error("pdma_chan: register bytes must be 8 bits wide");
      end
   endgenerate

   logic [7:0]    cfg_q;
   logic          wrap_q;
   logic [AW-1:0] base_q, cnt_q, ofs_q;
   logic [AW-1:0] ofs_inc;
   logic          at_end;
   logic          ofs_sw;

   assign ofs_inc = ofs_q + AW'(1);
   assign at_end  = (ofs_inc == cnt_q);
   assign ofs_sw  = bank_we && (reg_addr == RA_OFS_H || reg_addr == RA_OFS_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         wrap_q <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (bank_we) begin
         case (reg_addr)
            RA_CFG:    cfg_q            <= reg_wdata;
            RA_MODE:   wrap_q           <= reg_wdata[0];
            RA_BASE_H: base_q[AW-1:8]   <= reg_wdata[HW-1:0];
            RA_BASE_L: base_q[7:0]      <= reg_wdata;
            RA_CNT_H:  cnt_q[AW-1:8]    <= reg_wdata[HW-1:0];
            RA_CNT_L:  cnt_q[7:0]       <= reg_wdata;
            default:   ;
         endcase
      end
   end

   // software writes to the offset win over a hardware step in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= '0;
      end else if (ofs_sw) begin
         if (reg_addr == RA_OFS_H) ofs_q[AW-1:8] <= reg_wdata[HW-1:0];
         else                      ofs_q[7:0]    <= reg_wdata;
      end else if (step) begin
         ofs_q <= (at_end && wrap_q) ? '0 : ofs_inc;
      end
   end

   assign addr   = base_q + ofs_q;
   assign code   = cfg_q[CODE_W-1:0];
   assign irq_en = cfg_q[CFG_IE_BIT];
   assign done   = step && at_end && !wrap_q;

   logic [15:0] base_x, cnt_x, ofs_x;
   always_comb begin
      base_x = '0;
      cnt_x  = '0;
      ofs_x  = '0;
      base_x[AW-1:0] = base_q;
      cnt_x[AW-1:0]  = cnt_q;
      ofs_x[AW-1:0]  = ofs_q;
      case (reg_addr)
         RA_CFG:    bank_rdata = cfg_q;
         RA_MODE:   bank_rdata = {7'b0, wrap_q};
         RA_BASE_H: bank_rdata = hi_byte(base_x);
         RA_BASE_L: bank_rdata = lo_byte(base_x);
         RA_CNT_H:  bank_rdata = hi_byte(cnt_x);
         RA_CNT_L:  bank_rdata = lo_byte(cnt_x);
         RA_OFS_H:  bank_rdata = hi_byte(ofs_x);
         RA_OFS_L:  bank_rdata = lo_byte(ofs_x);
         default:   bank_rdata = '0;
      endcase
   end

   // R8: a replay channel that uses its last byte restarts at offset zero
   a_r8_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (step && wrap_q && at_end && !ofs_sw) |=> (ofs_q == '0));

   // R3/R4: a step without a software write advances the offset by exactly one or wraps
   a_r4_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ofs_sw) |=> ((ofs_q == $past(ofs_q) + AW'(1)) || (ofs_q == '0)));

   // R3: the offset holds steady when nothing touches it
   a_r3_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !ofs_sw) |=> $stable(ofs_q));

endmodule

// File: rtl/pdma_arb.sv
module pdma_arb #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   generate
      if (N < 1) begin : g_bad_n
         $error("pdma_arb: N must be at least 1");
      end
   endgenerate

   // lowest index wins
   always_comb begin
      gnt = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) gnt = N'(1) << i;
      end
   end

   // R12: one grant at most per cycle
   a_r12_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R12: grants only go to requesters, and nobody waits while the arbiter is idle
   a_r12_grant_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt & ~req) == '0) && ((req != '0) == (gnt != '0)));

   // R12: no requester below the granted one
   a_r12_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt - N'(1)) & req & ~gnt) == '0);

endmodule

// File: rtl/pdma_route.sv
module pdma_route
   import pdma_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned NIN = 3,
   parameter int unsigned AW  = 16,
   parameter int unsigned DW  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH-1:0]        ch_arm,
   input  logic [NCH*CODE_W-1:0] ch_code,
   input  logic [NCH*AW-1:0]     ch_addr,
   input  logic                  mem_ready,
   input  logic [DW-1:0]         mem_rdata,
   input  logic [NIN-1:0]        pin_ready,
   input  logic                  pout_valid,
   input  logic [DW-1:0]         pout_data,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [AW-1:0]         mem_addr,
   output logic [DW-1:0]         mem_wdata,
   output logic [NIN-1:0]        pin_strobe,
   output logic [DW-1:0]         pin_data,
   output logic                  pout_take,
   output logic [NCH-1:0]        step
);

   localparam int unsigned OUT_CODE = EP_FIRST_IN + NIN;

   generate
      if (OUT_CODE >= (1 << CODE_W)) begin : g_bad_nin
         $error("pdma_route: endpoint codes do not fit the config field");
      end
   endgenerate

   logic [NIN-1:0] in_hit [NCH];
   logic [NCH-1:0] out_hit;
   logic [NCH-1:0] port_ok;
   logic [NCH-1:0] req, gnt;

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_ch
         logic [CODE_W-1:0] cd;
         assign cd = ch_code[c*CODE_W +: CODE_W];
         always_comb begin
            in_hit[c] = '0;
            for (int k = 0; k < NIN; k++) begin
               if (cd == CODE_W'(EP_FIRST_IN + k)) in_hit[c][k] = 1'b1;
            end
         end
         assign out_hit[c] = (cd == CODE_W'(OUT_CODE));
         assign port_ok[c] = (|(in_hit[c] & pin_ready)) || (out_hit[c] && pout_valid);
         assign req[c]     = ch_arm[c] && port_ok[c] && mem_ready;
      end
   endgenerate

   pdma_arb #(.N(NCH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .gnt   (gnt)
   );

   logic [NIN-1:0] sel_in;
   logic           sel_out;
   logic [AW-1:0]  sel_addr;

   always_comb begin
      sel_in   = '0;
      sel_out  = 1'b0;
      sel_addr = '0;
      for (int i = 0; i < NCH; i++) begin
         if (gnt[i]) begin
            sel_in   = in_hit[i];
            sel_out  = out_hit[i];
            sel_addr = ch_addr[i*AW +: AW];
         end
      end
   end

   assign step       = gnt;
   assign mem_req    = |gnt;
   assign mem_we     = sel_out;
   assign mem_addr   = sel_addr;
   assign mem_wdata  = pout_data;
   assign pin_strobe = sel_in;
   assign pin_data   = mem_rdata;
   assign pout_take  = sel_out;

   // R12: a byte moves only while memory is ready
   a_r12_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_ready);

   // R4/R5: exactly one port side is served per moved byte
   a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones({pin_strobe, pout_take}) == 1));

   // R4: a strobe never lands on a port that is not ready
   a_r4_port_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_strobe & ~pin_ready) == '0);

   // R5: the output port is popped only while it holds a byte
   a_r5_take_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pout_take |-> (pout_valid && mem_we));

endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
   import pdma_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned NIN = 3,
   parameter int unsigned AW  = 16,
   parameter int unsigned DW  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ready,
   input  logic [NIN-1:0]    pin_ready,
   output logic [NIN-1:0]    pin_strobe,
   output logic [DW-1:0]     pin_data,
   input  logic              pout_valid,
   input  logic [DW-1:0]     pout_data,
   output logic              pout_take,
   output logic              irq
);

   localparam int unsigned SELW = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         $error("pdma_engine: NCH must fit one register byte");
      end
      if (NIN < 1) begin : g_bad_nin
         $error("pdma_engine: at least one input port is required");
      end
   endgenerate

   logic [NCH-1:0]        arm_q, flag_q;
   logic [SELW-1:0]       bank_q;
   logic [NCH-1:0]        step, done, irq_en;
   logic [NCH*CODE_W-1:0] ch_code;
   logic [NCH*AW-1:0]     ch_addr;
   logic [DW-1:0]         bank_rd [NCH];
   logic                  we_arm, we_flag, we_bank;

   assign we_arm  = reg_we && (reg_addr == RA_ARM);
   assign we_flag = reg_we && (reg_addr == RA_FLAG);
   assign we_bank = reg_we && (reg_addr == RA_BANK);

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_chan
         pdma_chan #(.AW(AW), .DW(DW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .bank_we    (reg_we && (bank_q == SELW'(c))),
            .reg_addr   (reg_addr),
            .reg_wdata  (reg_wdata),
            .step       (step[c]),
            .bank_rdata (bank_rd[c]),
            .code       (ch_code[c*CODE_W +: CODE_W]),
            .irq_en     (irq_en[c]),
            .addr       (ch_addr[c*AW +: AW]),
            .done       (done[c])
         );
      end
   endgenerate

   pdma_route #(.NCH(NCH), .NIN(NIN), .AW(AW), .DW(DW)) u_route (
      .clk        (clk),
      .rst_n      (rst_n),
      .ch_arm     (arm_q),
      .ch_code    (ch_code),
      .ch_addr    (ch_addr),
      .mem_ready  (mem_ready),
      .mem_rdata  (mem_rdata),
      .pin_ready  (pin_ready),
      .pout_valid (pout_valid),
      .pout_data  (pout_data),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .pin_strobe (pin_strobe),
      .pin_data   (pin_data),
      .pout_take  (pout_take),
      .step       (step)
   );

   // shared arm register: software write wins, finished linear channels disarm
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arm_q <= '0;
      else if (we_arm) arm_q <= reg_wdata[NCH-1:0];
      else             arm_q <= arm_q & ~done;
   end

   // shared flag register: zeros written clear, a new completion always sets
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (we_flag ? (flag_q & reg_wdata[NCH-1:0]) : flag_q) | done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q <= '0;
      else if (we_bank) bank_q <= reg_wdata[SELW-1:0];
   end

   assign irq = |(flag_q & irq_en);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_ARM:  reg_rdata[NCH-1:0]  = arm_q;
         RA_FLAG: reg_rdata[NCH-1:0]  = flag_q;
         RA_BANK: reg_rdata[SELW-1:0] = bank_q;
         default: begin
            for (int i = 0; i < NCH; i++) begin
               if (bank_q == SELW'(i)) reg_rdata = bank_rd[i];
            end
         end
      endcase
   end

   // R7: a completing channel is disarmed and flagged on the next cycle
   a_r7_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      ((done != '0) && !we_arm) |=> ((arm_q & $past(done)) == '0));

   a_r7_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (done != '0) |=> ((flag_q & $past(done)) == $past(done)));

   // R11: clearing the arm register stops all traffic on the next cycle
   a_r11_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (we_arm && (reg_wdata[NCH-1:0] == '0)) |=> !mem_req);

   // R6/R12: only armed channels move bytes
   a_r12_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
      (step & ~arm_q) == '0);

   // R9: the interrupt line needs a set flag
   a_r9_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flag_q != '0));

   // R10: without a completion, a flag never rises
   a_r10_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (done == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

endmodule

// File: tb/sim_pdma_engine.sv
`timescale 1ns/100ps
module sim_pdma_engine;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [7:0] mem_wdata, mem_rdata;
   logic       mem_ready = 1'b0;
   logic [2:0] pin_ready = '0;
   logic [2:0] pin_strobe;
   logic [7:0] pin_data;
   logic       pout_valid = 1'b0;
   logic [7:0] pout_data = '0;
   logic       pout_take, irq;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[15:8] ^ {a[6:0], a[7]} ^ 8'h5A;
   endfunction

   assign mem_rdata = pat(mem_addr);

   pdma_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .pin_ready(pin_ready),
      .pin_strobe(pin_strobe), .pin_data(pin_data), .pout_valid(pout_valid),
      .pout_data(pout_data), .pout_take(pout_take), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // inputs change 0.5 ns after a rising edge
   task automatic wr(input int a, input int d);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
      @(posedge clk); #0.5;
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string req);
      reg_addr = 4'(a);
      #1;
      chk(reg_rdata == 8'(exp), req, reg_rdata, exp, $sformatf("reg %0d", a));
   endtask

   task automatic setup(input int ch, input int cfg, input int mode, input int base, input int cnt);
      wr(2, ch); wr(3, cfg); wr(4, mode);
      wr(5, base >> 8); wr(6, base & 8'hFF);
      wr(7, cnt >> 8);  wr(8, cnt & 8'hFF);
      wr(9, 0); wr(10, 0);
   endtask

   // drives readiness per cycle and checks each cycle against an arithmetic model
   task automatic run_single(input int code, input int base, input int cnt, input bit wrap,
                             input int ncyc, input int rmod, input int mmod, input string req);
      int moved = 0;
      for (int i = 0; i < ncyc; i++) begin
         bit rdy, mrdy, go;
         int ofs;
         rdy  = (rmod == 0) || ((i % rmod) != 1);
         mrdy = (mmod == 0) || ((i % mmod) != (mmod - 1));
         pin_ready  = rdy ? 3'b111 : 3'b000;
         pout_valid = rdy;
         pout_data  = 8'h3C ^ 8'(i * 7);
         mem_ready  = mrdy;
         #1.5;
         go  = rdy && mrdy && (wrap || moved < cnt);
         ofs = wrap ? (moved % cnt) : moved;
         if (code == 8) begin
            chk(pout_take == go && mem_we == go && pin_strobe == 3'b000, req, {pout_take, mem_we}, {go, go}, "take/we");
            if (go) chk(mem_addr == 16'(base + ofs) && mem_wdata == pout_data, req, mem_addr, 16'(base + ofs), "write addr/data");
         end else begin
            logic [2:0] es;
            es = go ? 3'(1 << (code - 5)) : 3'b000;
            chk(pin_strobe == es && !mem_we && !pout_take, req, pin_strobe, es, "strobe");
            if (go) chk(mem_addr == 16'(base + ofs) && pin_data == pat(16'(base + ofs)), req, mem_addr, 16'(base + ofs), "read addr/data");
         end
         if (go) moved++;
         @(posedge clk); #0.5;
      end
      pin_ready = '0; pout_valid = 1'b0; mem_ready = 1'b0;
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #12 rst_n = 1'b1;
      @(posedge clk); #0.5;

      // R1: reset state
      for (int a = 0; a < 11; a++) rd_chk(a, 0, "R1");
      chk(!irq && !mem_req, "R1", {irq, mem_req}, 0, "irq/mem_req");

      // R2/R3: banked registers hold per-channel values
      for (int ch = 0; ch < 4; ch++) setup(ch, 8'h10 + ch, ch & 1, 16'hA100 + ch * 16'h0111, 16'h0300 + ch);
      for (int ch = 0; ch < 4; ch++) begin
         wr(2, ch);
         rd_chk(2, ch, "R2");
         rd_chk(3, 8'h10 + ch, "R2");
         rd_chk(4, ch & 1, "R2");
         rd_chk(5, (16'hA100 + ch * 16'h0111) >> 8, "R3");
         rd_chk(6, (16'hA100 + ch * 16'h0111) & 8'hFF, "R3");
         rd_chk(7, 8'h03, "R3");
         rd_chk(8, ch, "R3");
      end

      // R4/R7/R9: linear run to port 0 with interrupt enabled
      setup(0, 8'h85, 0, 16'h12FD, 6);
      wr(0, 1);
      run_single(5, 16'h12FD, 6, 0, 10, 0, 0, "R4");
      rd_chk(0, 0, "R7");
      rd_chk(1, 1, "R7");
      chk(irq == 1'b1, "R9", irq, 1, "irq after done");
      rd_chk(10, 6, "R3");

      // R10: writing ones keeps, writing zero clears
      wr(1, 8'hFF);
      rd_chk(1, 1, "R10");
      wr(1, 8'hFE);
      rd_chk(1, 0, "R10");
      chk(irq == 1'b0, "R10", irq, 0, "irq after clear");

      // R12/R4: stalls from the port and memory sides, carry into the high byte
      setup(1, 8'h06, 0, 16'h00FE, 4);
      wr(0, 2);
      run_single(6, 16'h00FE, 4, 0, 16, 3, 4, "R12");
      rd_chk(1, 2, "R7");
      chk(irq == 1'b0, "R9", irq, 0, "masked irq");
      wr(1, 0);

      // R5: output port into memory
      setup(3, 8'h88, 0, 16'h40FF, 5);
      wr(0, 8);
      run_single(8, 16'h40FF, 5, 0, 12, 2, 0, "R5");
      rd_chk(1, 8, "R7");
      rd_chk(0, 0, "R7");
      chk(irq == 1'b1, "R9", irq, 1, "irq port 3");
      wr(1, 0);

      // R8: replay across a 4 KB boundary
      setup(2, 8'h87, 1, 16'h2FFE, 3);
      wr(0, 4);
      run_single(7, 16'h2FFE, 3, 1, 11, 0, 0, "R8");
      rd_chk(0, 4, "R8");
      rd_chk(1, 0, "R8");
      rd_chk(10, 2, "R8");
      chk(irq == 1'b0, "R8", irq, 0, "no irq in replay");

      // R11: clearing arm halts everything
      wr(0, 0);
      pin_ready = 3'b111; mem_ready = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1.5;
         chk(!mem_req && pin_strobe == 3'b000, "R11", mem_req, 0, "halted");
         @(posedge clk); #0.5;
      end
      pin_ready = '0; mem_ready = 1'b0;

      // R6: unknown endpoint code never moves and stays armed
      setup(0, 8'h03, 0, 16'h0000, 2);
      wr(0, 1);
      pin_ready = 3'b111; pout_valid = 1'b1; mem_ready = 1'b1;
      for (int i = 0; i < 5; i++) begin
         #1.5;
         chk(!mem_req && !pout_take && pin_strobe == 3'b000, "R6", mem_req, 0, "no move");
         @(posedge clk); #0.5;
      end
      pin_ready = '0; pout_valid = 1'b0; mem_ready = 1'b0;
      rd_chk(0, 1, "R6");
      rd_chk(10, 0, "R6");
      wr(0, 0);

      // R12: two channels compete, lowest first
      setup(0, 8'h05, 0, 16'h0100, 2);
      setup(1, 8'h06, 0, 16'h0200, 2);
      wr(0, 3);
      pin_ready = 3'b111; mem_ready = 1'b1;
      for (int i = 0; i < 6; i++) begin
         logic [2:0]  es;
         logic [15:0] ea;
         es = (i < 2) ? 3'b001 : (i < 4) ? 3'b010 : 3'b000;
         ea = (i < 2) ? 16'(16'h0100 + i) : 16'(16'h0200 + i - 2);
         #1.5;
         chk(pin_strobe == es, "R12", pin_strobe, es, "priority strobe");
         if (es != 0) chk(mem_addr == ea, "R12", mem_addr, ea, "priority addr");
         @(posedge clk); #0.5;
      end
      pin_ready = '0; mem_ready = 1'b0;
      rd_chk(1, 3, "R7");
      rd_chk(0, 0, "R7");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule